// File: doc/BRIEF.md
# Bit-Plane Transposed Search Pixel Store

This block holds search-area pixels for a block-matching motion search. The search runs in two passes: a coarse pass that looks only at the top two bits of each pixel, then a refinement pass that needs every bit. A plain store with one pixel per word makes the coarse pass read just as many words as the fine pass. This store rearranges the pixels as they are written so that the coarse pass touches a quarter of the words. The word width and the word count stay those of a plain one-pixel-per-word memory.

Pixels arrive one per cycle on the write port and are grouped in fours. Each finished group is written as four words. Every word carries one two-bit slice, taken from all four pixels of the group. Groups fill consecutive slots and the slot pointer wraps at the end of the store. On the read side, a caller names a group and picks a mode. A coarse read returns the top two bits of all four pixels from one word access. A full read fetches the group's four words on four consecutive cycles. It holds the first three in delay registers and returns the four rebuilt pixels together with the last word.

Top module: `bitplane_store`

## Requirements
- R1: While reset is held and in the cycles after it is released, with no read request, `out_valid` stays low.
- R2: Each run of four consecutive accepted pixels forms one group. Groups go to slots 0, 1, 2, ... in order and wrap to slot 0 after slot NUM_GROUPS-1, so a later group overwrites the earlier one in that slot. Pixels may arrive on every cycle without a gap between groups.
- R3: A group is stored as four words. The word at offset j holds pixel bits [7-2j:6-2j] (offset 0 holds the two MSBs). Within every word, pixel k of the group sits in bits [2k+1:2k].
- R4: A coarse read (`rd_req`=1, `rd_full`=0) accepted on a clock edge gives `out_valid`=1 and `out_full`=0 for the cycle right after that edge. Each output lane carries the two MSBs of its pixel in bits 7:6, and bits 5:0 are zero.
- R5: A full read (`rd_req`=1, `rd_full`=1) accepted on edge E gives one cycle of `out_valid`=1 with `out_full`=1 after edge E+3. The output carries all four original 8-bit pixels.
- R6: Read requests that arrive on the three edges after a full read is accepted are ignored: they produce no output. A new request is accepted on the edge right after the full result appears, so full reads can run every four cycles.
- R7: Coarse reads can be accepted on every cycle, and each one produces one result in request order.
- R8: Writes continue while reads are in progress. A read of one group is not disturbed by writes to other groups.
- R9: In both modes, pixel k of the group (k-th pixel written) comes out on `out_pixels[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A pixel is present on `wr_pixel` this cycle |
| wr_pixel | input | 8 | Pixel to store |
| rd_req | input | 1 | Read request |
| rd_full | input | 1 | Read mode: 1 full resolution, 0 two-MSB coarse |
| rd_group | input | $clog2(NUM_GROUPS) | Group slot to read |
| out_valid | output | 1 | Result present on `out_pixels` |
| out_full | output | 1 | The present result is a full-resolution one |
| out_pixels | output | 32 | Four result pixels, pixel k on bits [8k+7:8k] |

## Verification
The bench builds the store with NUM_GROUPS set to 4, so writing a fifth and sixth group wraps the slot pointer and overwrites slots 0 and 1. A later read can then show the overwrite, and also show that slot 2 was left alone. With only four slots, every slot is both read and rewritten within a short run. That brings the pointer wrap, overlapping group drains and writes during full reads into view in a few hundred cycles. The chosen pixel values put different patterns in every two-bit slice, so a misplaced slice or a swapped lane changes the result.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    localparam int PIX_W   = 8;
    localparam int LANES   = 4;
    localparam int SLICE_W = 2;
    localparam int PLANES  = PIX_W / SLICE_W;
    localparam int OFF_W   = $clog2(PLANES);

    typedef logic [PIX_W-1:0]         pix_t;
    typedef pix_t [LANES-1:0]         group_t;
    typedef logic [LANES*SLICE_W-1:0] word_t;
    typedef word_t [PLANES-1:0]       planes_t;

    // Word at plane offset j: slice [PIX_W-1-SLICE_W*j -: SLICE_W] of each pixel
    function automatic word_t plane_word(group_t g, logic [OFF_W-1:0] j);
        word_t w;
        int base;
        base = PIX_W - SLICE_W * (int'(j) + 1);
        for (int k = 0; k < LANES; k++) begin
            w[k*SLICE_W +: SLICE_W] = g[k][base +: SLICE_W];
        end
        return w;
    endfunction

    // Inverse of plane_word over all offsets
    function automatic group_t rebuild(planes_t p);
        group_t g;
        for (int j = 0; j < PLANES; j++) begin
            for (int k = 0; k < LANES; k++) begin
                g[k][PIX_W - SLICE_W*(j+1) +: SLICE_W] = p[j][k*SLICE_W +: SLICE_W];
            end
        end
        return g;
    endfunction

    // Coarse view: top slice only, remaining bits zero
    function automatic group_t msb_only(word_t w);
        group_t g;
        for (int k = 0; k < LANES; k++) begin
            g[k] = {w[k*SLICE_W +: SLICE_W], {(PIX_W-SLICE_W){1'b0}}};
        end
        return g;
    endfunction

endpackage

// File: rtl/bpt_packer.sv
module bpt_packer
    import bpt_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    localparam int GRP_W = $clog2(NUM_GROUPS),
    localparam int AW    = GRP_W + OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  pix_t          in_pix,
    output logic          we,
    output logic [AW-1:0] waddr,
    output word_t         wdata
);

    logic [OFF_W-1:0] fill_cnt;
    group_t           stage;
    group_t           incoming;
    group_t           drain_q;
    logic             drain_on;
    logic [OFF_W-1:0] drain_off;
    logic [GRP_W-1:0] drain_grp;
    logic [GRP_W-1:0] wr_ptr;
    logic             load;

    assign load = in_valid && (fill_cnt == OFF_W'(LANES-1));

    always_comb begin
        incoming = stage;
        incoming[LANES-1] = in_pix;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt  <= '0;
            stage     <= '0;
            drain_q   <= '0;
            drain_on  <= 1'b0;
            drain_off <= '0;
            drain_grp <= '0;
            wr_ptr    <= '0;
        end else begin
            if (in_valid) begin
                fill_cnt        <= fill_cnt + 1'b1;
                stage[fill_cnt] <= in_pix;
            end
            if (load) begin
                drain_q   <= incoming;
                drain_on  <= 1'b1;
                drain_off <= '0;
                drain_grp <= wr_ptr;
                wr_ptr    <= (wr_ptr == GRP_W'(NUM_GROUPS-1)) ? '0 : wr_ptr + 1'b1;
            end else if (drain_on) begin
                drain_off <= drain_off + 1'b1;
                if (drain_off == OFF_W'(PLANES-1)) drain_on <= 1'b0;
            end
        end
    end

    assign we    = drain_on;
    assign waddr = {drain_grp, drain_off};
    assign wdata = plane_word(drain_q, drain_off);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (!drain_on || drain_off == OFF_W'(PLANES-1)));

    // R2
    drain_span_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_on && drain_off != OFF_W'(PLANES-1)) |=> drain_on);

endmodule

// File: rtl/bpt_ram.sv
module bpt_ram
    import bpt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/bpt_reader.sv
module bpt_reader
    import bpt_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    localparam int GRP_W = $clog2(NUM_GROUPS),
    localparam int AW    = GRP_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             full,
    input  logic [GRP_W-1:0] grp,
    output logic             re,
    output logic [AW-1:0]    raddr,
    input  word_t            rdata,
    output logic             out_valid,
    output logic             out_full,
    output group_t           out_pix
);

    logic             busy;
    logic [OFF_W-1:0] phase;
    logic [GRP_W-1:0] grp_q;
    logic             lo_v;
    logic             fu_v;
    planes_t          dly;
    planes_t          planes;
    logic             accept;

    assign accept = req && !busy;
    assign re     = accept || busy;
    assign raddr  = busy ? {grp_q, phase} : {grp, OFF_W'(0)};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= '0;
            grp_q <= '0;
            lo_v  <= 1'b0;
            fu_v  <= 1'b0;
            dly   <= '0;
        end else begin
            lo_v <= accept && !full;
            fu_v <= busy && (phase == OFF_W'(PLANES-1));
            if (accept && full) begin
                busy  <= 1'b1;
                phase <= OFF_W'(1);
                grp_q <= grp;
            end else if (busy) begin
                dly[phase - 1'b1] <= rdata;
                phase <= phase + 1'b1;
                if (phase == OFF_W'(PLANES-1)) busy <= 1'b0;
            end
        end
    end

    always_comb begin
        planes = dly;
        planes[PLANES-1] = rdata;
    end

    assign out_valid = lo_v || fu_v;
    assign out_full  = fu_v;
    assign out_pix   = fu_v ? rebuild(planes) : msb_only(rdata);

    // R4
    mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lo_v, fu_v}));

    // R6
    busy_no_lo_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !lo_v);

    // R5
    full_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fu_v |=> !fu_v);

    // R5
    full_src_chk: assert property (@(posedge clk) disable iff (rst)
        fu_v |-> $past(busy));

endmodule

// File: rtl/bitplane_store.sv
module bitplane_store
    import bpt_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    localparam int GRP_W = $clog2(NUM_GROUPS),
    localparam int AW    = GRP_W + OFF_W,
    localparam int DEPTH = NUM_GROUPS * PLANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [7:0]       wr_pixel,
    input  logic             rd_req,
    input  logic             rd_full,
    input  logic [GRP_W-1:0] rd_group,
    output logic             out_valid,
    output logic             out_full,
    output logic [31:0]      out_pixels
);

    logic          we;
    logic [AW-1:0] waddr;
    word_t         wdata;
    logic          re;
    logic [AW-1:0] raddr;
    word_t         rdata;
    group_t        pix_out;

    bpt_packer #(.NUM_GROUPS(NUM_GROUPS)) u_packer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (wr_valid),
        .in_pix   (wr_pixel),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata)
    );

    bpt_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .re    (re),
        .raddr (raddr),
        .rdata (rdata)
    );

    bpt_reader #(.NUM_GROUPS(NUM_GROUPS)) u_reader (
        .clk       (clk),
        .rst       (rst),
        .req       (rd_req),
        .full      (rd_full),
        .grp       (rd_group),
        .re        (re),
        .raddr     (raddr),
        .rdata     (rdata),
        .out_valid (out_valid),
        .out_full  (out_full),
        .out_pix   (pix_out)
    );

    assign out_pixels = pix_out;

endmodule

// File: tb/bitplane_store_bench.sv
module bitplane_store_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 4;
    localparam int GW = $clog2(NG);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_pixel = '0;
    logic          rd_req = 1'b0;
    logic          rd_full = 1'b0;
    logic [GW-1:0] rd_group = '0;
    logic          out_valid;
    logic          out_full;
    logic [31:0]   out_pixels;

    bitplane_store #(.NUM_GROUPS(NG)) u_bitplane_store (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_pixel   (wr_pixel),
        .rd_req     (rd_req),
        .rd_full    (rd_full),
        .rd_group   (rd_group),
        .out_valid  (out_valid),
        .out_full   (out_full),
        .out_pixels (out_pixels)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        full;
        logic [31:0] pix;
        int          due;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] model [NG][4];
    int         wptr = 0;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] expect_pix(int g, bit full);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            r[8*k +: 8] = full ? model[g][k] : (model[g][k] & 8'hC0);
        end
        return r;
    endfunction

    task automatic write_group(input logic [7:0] a, input logic [7:0] b,
                               input logic [7:0] c, input logic [7:0] d);
        logic [7:0] p [4];
        p[0] = a; p[1] = b; p[2] = c; p[3] = d;
        for (int k = 0; k < 4; k++) model[wptr][k] = p[k];
        wptr = (wptr + 1) % NG;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_pixel = p[k];
        end
    endtask

    task automatic wr_stop();
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic low_read(input int g, input string tag);
        exp_t e;
        @(negedge clk);
        rd_req = 1'b1; rd_full = 1'b0; rd_group = GW'(g);
        e.full = 1'b0; e.pix = expect_pix(g, 1'b0); e.due = cyc + 1; e.tag = tag;
        sb.push_back(e);
    endtask

    // first request accepted, the next three must be ignored (R6)
    task automatic full_read(input int g, input string tag);
        exp_t e;
        @(negedge clk);
        rd_req = 1'b1; rd_full = 1'b1; rd_group = GW'(g);
        e.full = 1'b1; e.pix = expect_pix(g, 1'b1); e.due = cyc + 4; e.tag = tag;
        sb.push_back(e);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd_req = 1'b1; rd_full = i[0]; rd_group = GW'((g + 1) % NG);
        end
    endtask

    task automatic rd_stop();
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sb.size() > 0 && sb[0].due < cyc) begin
                checks++; errors++;
                $display("FAIL %s: missing result, actual none expected at cycle %0d", sb[0].tag, sb[0].due);
                void'(sb.pop_front());
            end
            if (out_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R6: unexpected result actual %h full=%0b expected none", out_pixels, out_full);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.due != cyc || e.full != out_full || e.pix != out_pixels) begin
                        errors++;
                        $display("FAIL %s: actual pix=%h full=%0b cyc=%0d expected pix=%h full=%0b cyc=%0d",
                                 e.tag, out_pixels, out_full, cyc, e.pix, e.full, e.due);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: no output while in reset
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid in reset actual %b expected 0", out_valid);
        end
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1: out_valid after reset actual %b expected 0", out_valid);
            end
        end

        // R2: four groups written without gaps
        write_group(8'h12, 8'h34, 8'h56, 8'h78);
        write_group(8'hFF, 8'h00, 8'h80, 8'h7F);
        write_group(8'hC3, 8'h3C, 8'hA5, 8'h5A);
        write_group(8'h01, 8'h40, 8'hBF, 8'hE7);
        wr_stop();
        idle(6);

        // R4 R7 R9 R3: coarse reads on every cycle
        low_read(0, "R4");
        low_read(1, "R7");
        low_read(2, "R9");
        low_read(3, "R3");
        rd_stop();
        idle(3);

        // R5 R6 R3: full reads every four cycles with ignored requests between
        full_read(0, "R5");
        full_read(1, "R6");
        full_read(2, "R3");
        full_read(3, "R9");
        rd_stop();
        idle(4);

        // R8: overwrite slots 0 and 1 while reading slots 3 and 2
        fork
            begin
                write_group(8'hAA, 8'h55, 8'hFF, 8'h00);
                write_group(8'h0F, 8'hF0, 8'h99, 8'h66);
                wr_stop();
            end
            begin
                full_read(3, "R8");
                full_read(2, "R8");
                low_read(3, "R8");
                rd_stop();
            end
        join
        idle(6);

        // R2: wrapped groups are visible, slot 2 untouched
        low_read(0, "R2");
        rd_stop();
        full_read(0, "R2");
        full_read(1, "R2");
        full_read(2, "R2");
        rd_stop();
        idle(8);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R5: pending results actual %0d expected 0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule